// File: doc/BRIEF.md
# Averaging 16-Point Complex FFT Engine

This block computes a 16-point complex discrete Fourier transform on one frame at a time. A frame of 16 complex 12-bit samples is written through a load port, one sample per cycle, addressed by its time index. A start strobe then runs four radix-2 decimation-in-time passes in place over an internal register file, with one butterfly unit doing eight butterflies per pass. When the last pass is written, a one-cycle done pulse appears, and each frequency bin can then be read combinationally by its bin number.

Each butterfly returns the halved sum and the halved difference of its operands instead of the plain sum and difference. Four passes therefore scale the result by exactly 1/16, and no intermediate value grows beyond the input range. This keeps every operation at or below unit gain, the way charge-sharing arithmetic does. Twiddle factors are fixed powers of exp(-2*pi*j/16), kept as signed fractions of magnitude at most one. The unit factor and the -j factor skip the multiplier entirely.

Top module: `fft16_avg`

## Requirements
- R1: After a frame is processed, reading bin k (0..15, natural order) returns (1/16)·sum over n of x[n]·exp(-2πj·n·k/16), real and imaginary parts each within ±2 LSB, for any input whose complex samples have magnitude at most 2047.
- R2: Each of the four passes halves with round-half-up, floor((v+1)/2). An impulse of value v at time index 0, with all other samples zero, therefore gives exactly the value obtained by applying floor((v+1)/2) four times, in both components of every bin.
- R3: done goes high exactly 32 clock cycles after the edge that samples start, and it stays high for a single cycle.
- R4: busy is high from the cycle after start is sampled until the cycle in which done is high, and it is low in that cycle.
- R5: A load pulse that arrives while busy is high is ignored. A load pulse while idle writes sample loadIdx of the next frame.
- R6: A start pulse that arrives while busy is high is ignored: the run is not restarted and no extra done pulse occurs.
- R7: After reset, busy and done are low and every bin reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins processing of the loaded frame when idle |
| loadValid | input | 1 | Writes one input sample this cycle when idle |
| loadIdx | input | 4 | Time index of the sample being written |
| loadRe | input | DW (12) | Real part of the sample, signed |
| loadIm | input | DW (12) | Imaginary part of the sample, signed |
| rdIdx | input | 4 | Bin number to read |
| busy | output | 1 | High while the passes run |
| done | output | 1 | One-cycle pulse once the transform is complete |
| outRe | output | DW (12) | Real part of bin rdIdx, signed |
| outIm | output | DW (12) | Imaginary part of bin rdIdx, signed |

## Verification
The transform is driven with impulses at bin 0 and at odd and even positions, a DC level, complex exponentials on low, middle and wrapped frequencies, a real cosine, a ramp and an alternating sequence. Each is compared with a double-precision DFT divided by 16. The impulse positions expose reordering and twiddle-index errors, since the phase of every bin depends on where the impulse sits. The tones and the cosine single out wrong twiddle values and wrong signs, because a fault moves energy into the wrong bin or into its mirror. A zero-position impulse with an odd value pins down the exact rounding of each halving. Separate runs inject a load and a second start in the middle of a run to show that neither disturbs the result or its timing.

// File: rtl/fft16_pkg.sv
`timescale 1ns/1ps
package fft16_pkg;
  localparam int NPTS = 16;
  localparam int LOGN = $clog2(NPTS);
  localparam int BFLY = NPTS / 2;
  localparam int AW   = LOGN;
  localparam int SW   = $clog2(LOGN);
  localparam int IW   = $clog2(BFLY);

  typedef struct packed {
    logic          loadEn;
    logic          bfly;
    logic [SW-1:0] stage;
    logic [IW-1:0] idx;
  } fftCmd_t;
endpackage

// File: rtl/fft16_ctrl.sv
`timescale 1ns/1ps
module fft16_ctrl
  import fft16_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    loadValid,
  output fftCmd_t cmd,
  output logic    busy,
  output logic    done
);
  logic [SW-1:0] stageQ;
  logic [IW-1:0] idxQ;
  logic          lastBfly;

  assign lastBfly = (stageQ == SW'(LOGN - 1)) && (idxQ == IW'(BFLY - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      stageQ <= '0;
      idxQ   <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          stageQ <= '0;
          idxQ   <= '0;
        end
      end else begin
        idxQ <= idxQ + 1'b1;
        if (idxQ == IW'(BFLY - 1)) begin
          if (lastBfly) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            stageQ <= stageQ + 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    cmd.loadEn = loadValid && !busy;
    cmd.bfly   = busy;
    cmd.stage  = stageQ;
    cmd.idx    = idxQ;
  end

  // R3: done lasts one cycle
  p_done_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R3: passes advance in order, each after its eighth butterfly
  p_stage_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && idxQ == IW'(BFLY - 1) && stageQ != SW'(LOGN - 1))
      |=> (busy && idxQ == '0 && stageQ == $past(stageQ) + 1'b1));

  // R4: a run only begins on a sampled start
  p_busy_start_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

  // R6: a second start cannot cut a run short
  p_start_ignored_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !lastBfly) |=> busy);
endmodule

// File: rtl/fft16_dp.sv
`timescale 1ns/1ps
module fft16_dp
  import fft16_pkg::*;
#(
  parameter int DW = 12,
  parameter int CW = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  fftCmd_t              cmd,
  input  logic [AW-1:0]        loadIdx,
  input  logic signed [DW-1:0] loadRe,
  input  logic signed [DW-1:0] loadIm,
  input  logic [AW-1:0]        rdIdx,
  output logic signed [DW-1:0] outRe,
  output logic signed [DW-1:0] outIm
);
  localparam int FRAC = CW - 1;
  localparam int ACCW = DW + CW + 2;
  localparam int C1 = (60547 * (2 ** FRAC) + 32768) / 65536;  // cos(pi/8)
  localparam int S1 = (25080 * (2 ** FRAC) + 32768) / 65536;  // sin(pi/8)
  localparam int C2 = (46341 * (2 ** FRAC) + 32768) / 65536;  // cos(pi/4)
  localparam logic signed [ACCW-1:0] RND  = ACCW'(1) <<< FRAC;
  localparam logic signed [ACCW-1:0] MAXV = ACCW'((2 ** (DW - 1)) - 1);
  localparam logic signed [ACCW-1:0] MINV = -ACCW'(2 ** (DW - 1));

  logic signed [DW-1:0] memRe [NPTS];
  logic signed [DW-1:0] memIm [NPTS];

  function automatic logic [AW-1:0] bitRev(input logic [AW-1:0] a);
    logic [AW-1:0] r;
    for (int b = 0; b < AW; b++) r[b] = a[AW-1-b];
    return r;
  endfunction

  // Twiddle ROM: exp(-j*pi*k/8); k = 0 and k = 4 bypass the multiplier
  function automatic logic signed [2*CW-1:0] twid(input logic [IW-1:0] k);
    logic signed [CW-1:0] re, im;
    case (k)
      3'd1:    begin re = CW'(C1);  im = CW'(-S1); end
      3'd2:    begin re = CW'(C2);  im = CW'(-C2); end
      3'd3:    begin re = CW'(S1);  im = CW'(-C1); end
      3'd5:    begin re = CW'(-S1); im = CW'(-C1); end
      3'd6:    begin re = CW'(-C2); im = CW'(-C2); end
      3'd7:    begin re = CW'(-C1); im = CW'(-S1); end
      default: begin re = '0;       im = '0;       end
    endcase
    return {re, im};
  endfunction

  function automatic logic signed [DW-1:0] halveSat(input logic signed [ACCW-1:0] v);
    logic signed [ACCW-1:0] h;
    h = (v + RND) >>> (FRAC + 1);
    if (h > MAXV)      return DW'(MAXV);
    else if (h < MINV) return DW'(MINV);
    else               return DW'(h);
  endfunction

  // butterfly addressing for the current pass
  logic [AW-1:0] span, posPart, grp, iIdx, jIdx, kFull, wrSlot;
  logic [IW-1:0] twK;

  always_comb begin
    span    = AW'(1) << cmd.stage;
    posPart = {1'b0, cmd.idx} & (span - 1'b1);
    grp     = {1'b0, cmd.idx} >> cmd.stage;
    iIdx    = ((grp << cmd.stage) << 1) | posPart;
    jIdx    = iIdx | span;
    kFull   = posPart << (SW'(LOGN - 1) - cmd.stage);
    twK     = kFull[IW-1:0];
    wrSlot  = bitRev(loadIdx);
  end

  // shared butterfly: (a + W*b)/2 and (a - W*b)/2
  logic signed [DW-1:0]   aRe, aIm, bRe, bIm;
  logic signed [CW-1:0]   wRe, wIm;
  logic signed [ACCW-1:0] tRe, tIm, aRx, aIx;
  logic signed [DW-1:0]   sumRe, sumIm, difRe, difIm;

  always_comb begin
    aRe = memRe[iIdx];
    aIm = memIm[iIdx];
    bRe = memRe[jIdx];
    bIm = memIm[jIdx];
    {wRe, wIm} = twid(twK);
    aRx = ACCW'(aRe) <<< FRAC;
    aIx = ACCW'(aIm) <<< FRAC;
    case (twK)
      3'd0: begin
        tRe = ACCW'(bRe) <<< FRAC;
        tIm = ACCW'(bIm) <<< FRAC;
      end
      3'd4: begin                       // times -j: swap and negate
        tRe = ACCW'(bIm) <<< FRAC;
        tIm = -(ACCW'(bRe) <<< FRAC);
      end
      default: begin
        tRe = ACCW'(bRe) * ACCW'(wRe) - ACCW'(bIm) * ACCW'(wIm);
        tIm = ACCW'(bRe) * ACCW'(wIm) + ACCW'(bIm) * ACCW'(wRe);
      end
    endcase
    sumRe = halveSat(aRx + tRe);
    sumIm = halveSat(aIx + tIm);
    difRe = halveSat(aRx - tRe);
    difIm = halveSat(aIx - tIm);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int g = 0; g < NPTS; g++) begin
        memRe[g] <= '0;
        memIm[g] <= '0;
      end
    end else begin
      for (int g = 0; g < NPTS; g++) begin
        if (cmd.loadEn && wrSlot == AW'(g)) begin
          memRe[g] <= loadRe;
          memIm[g] <= loadIm;
        end else if (cmd.bfly && iIdx == AW'(g)) begin
          memRe[g] <= sumRe;
          memIm[g] <= sumIm;
        end else if (cmd.bfly && jIdx == AW'(g)) begin
          memRe[g] <= difRe;
          memIm[g] <= difIm;
        end
      end
    end
  end

  assign outRe = memRe[rdIdx];
  assign outIm = memIm[rdIdx];

  // R5: an accepted load lands at the bit-reversed slot
  p_load_lands_r5: assert property (@(posedge clk) disable iff (!rstN)
    cmd.loadEn |=> (memRe[$past(wrSlot)] == $past(loadRe)
                    && memIm[$past(wrSlot)] == $past(loadIm)));

  // R5: loading and butterflies never share a cycle
  p_load_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    cmd.bfly |-> !cmd.loadEn);
endmodule

// File: rtl/fft16_avg.sv
`timescale 1ns/1ps
module fft16_avg
  import fft16_pkg::*;
#(
  parameter int DW = 12,
  parameter int CW = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic                 loadValid,
  input  logic [3:0]           loadIdx,
  input  logic signed [DW-1:0] loadRe,
  input  logic signed [DW-1:0] loadIm,
  input  logic [3:0]           rdIdx,
  output logic                 busy,
  output logic                 done,
  output logic signed [DW-1:0] outRe,
  output logic signed [DW-1:0] outIm
);
  fftCmd_t cmd;

  fft16_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .loadValid (loadValid),
    .cmd       (cmd),
    .busy      (busy),
    .done      (done)
  );

  fft16_dp #(.DW(DW), .CW(CW)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .cmd     (cmd),
    .loadIdx (loadIdx),
    .loadRe  (loadRe),
    .loadIm  (loadIm),
    .rdIdx   (rdIdx),
    .outRe   (outRe),
    .outIm   (outIm)
  );
endmodule

// File: tb/sim_fft16_avg.sv
`timescale 1ns/1ps
module sim_fft16_avg;
  localparam int DW = 12;
  localparam real PI = 3.14159265358979323846;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic loadValid = 1'b0;
  logic [3:0] loadIdx = '0;
  logic signed [DW-1:0] loadRe = '0;
  logic signed [DW-1:0] loadIm = '0;
  logic [3:0] rdIdx = '0;
  logic busy, done;
  logic signed [DW-1:0] outRe, outIm;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int xr [16];
  int xi [16];

  // stimulus table: kind, frequency or position, amplitude
  // kind 0 impulse, 1 DC, 2 complex tone, 3 real cosine, 4 ramp, 5 alternating
  localparam int NV = 9;
  localparam int VKIND [NV] = '{1, 0, 0, 2, 2, 3, 4, 5, 2};
  localparam int VFREQ [NV] = '{0, 0, 5, 3, 13, 2, 0, 0, 1};
  localparam int VAMP  [NV] = '{1000, 1200, -900, 1400, 1400, 1400, 1400, 1000, -1400};

  fft16_avg #(.DW(DW), .CW(12)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .loadValid(loadValid),
    .loadIdx(loadIdx), .loadRe(loadRe), .loadIm(loadIm), .rdIdx(rdIdx),
    .busy(busy), .done(done), .outRe(outRe), .outIm(outIm)
  );

  always #5 clk = ~clk;

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected under 150000", cycles);
      summary();
      $finish;
    end
  end

  function automatic int rnd(real v);
    return $rtoi(v >= 0.0 ? v + 0.5 : v - 0.5);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic makeFrame(int kind, int f, int a);
    for (int n = 0; n < 16; n++) begin
      real ph;
      ph = 2.0 * PI * real'(f * n) / 16.0;
      case (kind)
        0: begin xr[n] = (n == f) ? a : 0; xi[n] = (n == f) ? -a / 2 : 0; end
        1: begin xr[n] = a; xi[n] = a / 3; end
        2: begin xr[n] = rnd(real'(a) * $cos(ph)); xi[n] = rnd(real'(a) * $sin(ph)); end
        3: begin xr[n] = rnd(real'(a) * $cos(ph)); xi[n] = 0; end
        4: begin xr[n] = (n * a) / 16 - a / 2; xi[n] = -xr[n]; end
        default: begin xr[n] = (n % 2 == 1) ? -a : a; xi[n] = a / 2; end
      endcase
    end
  endtask

  task automatic loadFrame();
    for (int n = 0; n < 16; n++) begin
      @(negedge clk);
      loadValid = 1'b1;
      loadIdx = 4'(n);
      loadRe = DW'(xr[n]);
      loadIm = DW'(xi[n]);
    end
    @(negedge clk);
    loadValid = 1'b0;
  endtask

  // runs one frame; optional mid-run load or start injection at cycle injAt
  task automatic runFrame(int injLoad, int injStart, output int lat);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    chk(busy == 1'b1, "R4", "busy after start", int'(busy), 1);
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
      loadValid = (lat == injLoad);
      loadIdx = 4'd0;
      loadRe = 12'sd2000;
      loadIm = -12'sd2000;
      start = (lat == injStart);
      if (!done && lat < 32)
        chk(busy == 1'b1, "R4", "busy held during run", int'(busy), 1);
    end
    loadValid = 1'b0;
    start = 1'b0;
    chk(busy == 1'b0, "R4", "busy low with done", int'(busy), 0);
  endtask

  task automatic checkRef(string tag);
    for (int k = 0; k < 16; k++) begin
      real sr, si, ang;
      sr = 0.0;
      si = 0.0;
      for (int n = 0; n < 16; n++) begin
        ang = -2.0 * PI * real'(n * k) / 16.0;
        sr += real'(xr[n]) * $cos(ang) - real'(xi[n]) * $sin(ang);
        si += real'(xr[n]) * $sin(ang) + real'(xi[n]) * $cos(ang);
      end
      sr = sr / 16.0;
      si = si / 16.0;
      rdIdx = 4'(k);
      #1;
      chk((real'(outRe) - sr <= 2.0) && (sr - real'(outRe) <= 2.0), tag,
          $sformatf("bin %0d re", k), int'(outRe), rnd(sr));
      chk((real'(outIm) - si <= 2.0) && (si - real'(outIm) <= 2.0), tag,
          $sformatf("bin %0d im", k), int'(outIm), rnd(si));
    end
  endtask

  initial begin
    int lat;
    int er, ei;
    repeat (3) @(negedge clk);
    // R7: reset state
    chk(busy == 1'b0, "R7", "busy in reset", int'(busy), 0);
    chk(done == 1'b0, "R7", "done in reset", int'(done), 0);
    rstN = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 16; k++) begin
      rdIdx = 4'(k);
      #1;
      chk(outRe == 0 && outIm == 0, "R7", $sformatf("bin %0d after reset", k),
          int'(outRe) + int'(outIm), 0);
    end
    chk(busy == 1'b0 && done == 1'b0, "R7", "idle after reset", int'(busy) + int'(done), 0);

    // R1: table of input patterns against a reference DFT / 16
    for (int v = 0; v < NV; v++) begin
      makeFrame(VKIND[v], VFREQ[v], VAMP[v]);
      loadFrame();
      runFrame(-1, -1, lat);
      chk(lat == 32, "R3", "start to done latency", lat, 32);
      @(negedge clk);
      chk(done == 1'b0, "R3", "done single cycle", int'(done), 0);
      checkRef("R1");
    end

    // R2: exact round-half-up halving, positive and negative odd impulses
    makeFrame(0, 0, 0);
    xr[0] = 23;
    xi[0] = -23;
    loadFrame();
    runFrame(-1, -1, lat);
    er = 23;
    ei = -23;
    for (int s = 0; s < 4; s++) begin
      er = (er + 1) >>> 1;
      ei = (ei + 1) >>> 1;
    end
    for (int k = 0; k < 16; k++) begin
      rdIdx = 4'(k);
      #1;
      chk(outRe == DW'(er), "R2", $sformatf("bin %0d re exact", k), int'(outRe), er);
      chk(outIm == DW'(ei), "R2", $sformatf("bin %0d im exact", k), int'(outIm), ei);
    end

    // R5: a load during the run is ignored
    makeFrame(2, 6, 1300);
    loadFrame();
    runFrame(5, -1, lat);
    chk(lat == 32, "R5", "latency with blocked load", lat, 32);
    checkRef("R5");

    // R6: a second start during the run is ignored
    makeFrame(0, 9, 1100);
    loadFrame();
    runFrame(-1, 10, lat);
    chk(lat == 32, "R6", "latency with extra start", lat, 32);
    lat = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (done) lat++;
    end
    chk(lat == 0, "R6", "no second done pulse", lat, 0);
    chk(busy == 1'b0, "R6", "stays idle", int'(busy), 0);
    checkRef("R6");

    summary();
    $finish;
  end
endmodule